// File: doc/BRIEF.md
# Flash Write-Status Read Multiplexer

This block sits in the read path of an emulated parallel NOR flash. When no internal write is running, a read returns the array byte unchanged. While an internal program or erase is busy, two bits of every read are replaced with status. Bit 7 is a polarity bit that depends on the kind of operation. Bit 6 flips on every accepted read. Software polls either bit to learn when the write has finished.

A read is accepted on the rising edge of a read-access strobe, but only while chip select and output enable are both low. The byte for that read is captured on the clock edge that sees the strobe rise, and it is held until the next accepted read. The command decoder outside this block raises `busy_i` only after the final write pulse of a program or erase sequence, and it pulses `op_start_i` when the internal operation begins. Tri-state output gating is represented by a valid flag: while the flag is low, the data bus reads as zero.

Top module: `wsr_read_mux`

## Requirements
- R1: During a busy program (`op_erase_i` = 0), bit 7 of an accepted read is the inverse of bit 7 of `prog_data_i`.
- R2: During a busy erase (`op_erase_i` = 1), bit 7 of an accepted read is 0.
- R3: During busy, bit 6 takes opposite values on consecutive accepted reads.
- R4: During busy, bits 5..0 of an accepted read equal bits 5..0 of `array_data_i`.
- R5: With `busy_i` low, an accepted read returns all 8 bits of `array_data_i`, and the toggle state does not advance.
- R6: A pulse on `op_start_i` clears the toggle, so the first busy read after a start returns bit 6 = 0.
- R7: A read is accepted only on the clock edge where `rd_strobe_i` is high and was low one clock earlier, with `ce_n_i` and `oe_n_i` both low. Any other strobe activity neither changes the held byte nor advances the toggle.
- R8: `rd_valid_o` is 1 exactly when `ce_n_i` and `oe_n_i` are both 0. While it is 0, `rd_data_o` is all zeros.
- R9: After synchronous reset (`rst_n` low), the held byte is 0 and the toggle is 0.
- R10: The byte of an accepted read appears on `rd_data_o` right after the accepting clock edge and stays there until the next accepted read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| busy_i | input | 1 | Internal program or erase in progress |
| op_erase_i | input | 1 | Operation kind: 0 program, 1 erase |
| op_start_i | input | 1 | One-cycle pulse when an internal operation begins |
| prog_data_i | input | 8 | Latched byte being programmed |
| array_data_i | input | 8 | Array contents at the read address |
| rd_strobe_i | input | 1 | Read-access strobe; its rising edge is a read |
| ce_n_i | input | 1 | Chip select, active low |
| oe_n_i | input | 1 | Output enable, active low |
| rd_data_o | output | 8 | Read data |
| rd_valid_o | output | 1 | Bus driven (stands in for tri-state enable) |

## Verification
Random programs and erases are run, with random program bytes and random array bytes. Using both polarities of program bit 7 separates the inverted-polling path from the constant-zero erase path. Changing the array byte on every read shows that only bits 7 and 6 are replaced during busy. Directed cases cover the following:
- strobes while deselected or with output enable high, which must not advance the toggle;
- a strobe held high, which counts as a single read;
- a restart, which clears the toggle;
- idle reads after completion, which return the whole array byte.

// File: rtl/wsr_pkg.sv
// Shared types for the write-status read multiplexer.
package wsr_pkg;
    typedef enum logic {
        OP_PROG  = 1'b0,
        OP_ERASE = 1'b1
    } op_kind_e;
endpackage

// File: rtl/wsr_strobe_edge.sv
// Rising-edge detector for the read-access strobe.
// Assumes the strobe is already synchronous to clk.
module wsr_strobe_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic strobe_i,
    output logic rise_o
);
    logic strobe_q;

    // Remember the strobe level from the previous clock.
    always_ff @(posedge clk) begin
        if (!rst_n) strobe_q <= 1'b0;
        else        strobe_q <= strobe_i;
    end

    // A rise is high now and low one clock earlier.
    always_comb rise_o = strobe_i & ~strobe_q;
endmodule

// File: rtl/wsr_toggle.sv
// Toggle-bit state. It is cleared when an operation starts and
// flips once per accepted busy read. A clear beats an advance.
module wsr_toggle (
    input  logic clk,
    input  logic rst_n,
    input  logic clear_i,
    input  logic adv_i,
    output logic tog_o
);
    // Hold, clear or invert the toggle state.
    always_ff @(posedge clk) begin
        if (!rst_n || clear_i) tog_o <= 1'b0;
        else if (adv_i)        tog_o <= ~tog_o;
    end
endmodule

// File: rtl/wsr_compose.sv
// Builds the read byte: status bits are substituted during busy,
// and the array byte passes straight through otherwise.
// Purely combinational.
module wsr_compose
    import wsr_pkg::*;
#(
    parameter int DW       = 8,
    parameter int POLL_BIT = 7,
    parameter int TOG_BIT  = 6
) (
    input  logic          busy_i,
    input  op_kind_e      op_i,
    input  logic [DW-1:0] prog_data_i,
    input  logic [DW-1:0] array_data_i,
    input  logic          tog_i,
    output logic [DW-1:0] data_o
);
    logic poll_val;

    // Polling value: the erased-state opposite (0) for erase,
    // the inverted program bit for program.
    always_comb poll_val = (op_i == OP_ERASE) ? 1'b0 : ~prog_data_i[POLL_BIT];

    // Per-bit choice between status and array data.
    for (genvar b = 0; b < DW; b++) begin : g_bit
        if (b == POLL_BIT) begin : g_poll
            assign data_o[b] = busy_i ? poll_val : array_data_i[b];
        end else if (b == TOG_BIT) begin : g_tog
            assign data_o[b] = busy_i ? tog_i : array_data_i[b];
        end else begin : g_pass
            assign data_o[b] = array_data_i[b];
        end
    end
endmodule

// File: rtl/wsr_read_mux.sv
// Top of the write-status read path. A read is accepted on a strobe
// rise while the part is selected with its outputs enabled. The
// composed byte is held until the next accepted read, and the output
// is zero while the bus is not driven.
module wsr_read_mux
    import wsr_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          busy_i,
    input  logic          op_erase_i,
    input  logic          op_start_i,
    input  logic [DW-1:0] prog_data_i,
    input  logic [DW-1:0] array_data_i,
    input  logic          rd_strobe_i,
    input  logic          ce_n_i,
    input  logic          oe_n_i,
    output logic [DW-1:0] rd_data_o,
    output logic          rd_valid_o
);
    localparam int POLL_BIT = DW - 1;
    localparam int TOG_BIT  = DW - 2;

    logic          rise;
    logic          rd_acc;
    logic          tog;
    logic [DW-1:0] composed;
    logic [DW-1:0] hold_q;
    op_kind_e      op_kind;

    wsr_strobe_edge u_edge (
        .clk      (clk),
        .rst_n    (rst_n),
        .strobe_i (rd_strobe_i),
        .rise_o   (rise)
    );

    // A read counts only when the part is selected and its outputs are enabled.
    always_comb rd_valid_o = ~ce_n_i & ~oe_n_i;
    always_comb rd_acc     = rise & rd_valid_o;
    always_comb op_kind    = op_kind_e'(op_erase_i);

    wsr_toggle u_tog (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear_i (op_start_i),
        .adv_i   (rd_acc & busy_i),
        .tog_o   (tog)
    );

    wsr_compose #(.DW(DW), .POLL_BIT(POLL_BIT), .TOG_BIT(TOG_BIT)) u_comp (
        .busy_i       (busy_i),
        .op_i         (op_kind),
        .prog_data_i  (prog_data_i),
        .array_data_i (array_data_i),
        .tog_i        (tog),
        .data_o       (composed)
    );

    // Capture the composed byte on each accepted read.
    always_ff @(posedge clk) begin
        if (!rst_n)      hold_q <= '0;
        else if (rd_acc) hold_q <= composed;
    end

    // Output gating stands in for the tri-state bus.
    always_comb rd_data_o = rd_valid_o ? hold_q : '0;
endmodule

// File: rtl/wsr_read_mux_chk.sv
// Property checker for wsr_read_mux. It rebuilds its own strobe-edge
// view and relates inputs to the byte presented one clock later.
module wsr_read_mux_chk #(
    parameter int DW = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic          busy_i,
    input logic          op_erase_i,
    input logic          op_start_i,
    input logic [DW-1:0] prog_data_i,
    input logic [DW-1:0] array_data_i,
    input logic          rd_strobe_i,
    input logic          ce_n_i,
    input logic          oe_n_i,
    input logic [DW-1:0] rd_data_o,
    input logic          rd_valid_o
);
    logic stb_q;
    logic acc;

    // Independent copy of the previous strobe level.
    always_ff @(posedge clk) begin
        if (!rst_n) stb_q <= 1'b0;
        else        stb_q <= rd_strobe_i;
    end

    always_comb acc = rd_strobe_i & ~stb_q & ~ce_n_i & ~oe_n_i;

    // R1: program polling bit is the inverse of the program data.
    a_r1_prog_poll: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && busy_i && !op_erase_i) |=>
            (!rd_valid_o || rd_data_o[DW-1] == ~$past(prog_data_i[DW-1])));

    // R2: erase polling bit reads 0.
    a_r2_erase_poll: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && busy_i && op_erase_i) |=> (!rd_valid_o || !rd_data_o[DW-1]));

    // R4: low bits pass through during busy.
    a_r4_low_bits: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && busy_i) |=>
            (!rd_valid_o || rd_data_o[DW-3:0] == $past(array_data_i[DW-3:0])));

    // R5: idle reads return the whole array byte.
    a_r5_idle_pass: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && !busy_i) |=> (!rd_valid_o || rd_data_o == $past(array_data_i)));

    // R8: undriven bus reads as zero.
    a_r8_gated_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (ce_n_i || oe_n_i) |-> (rd_data_o == '0 && !rd_valid_o));

    // R7: without an accepted read, a driven byte stays stable.
    a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!acc && !ce_n_i && !oe_n_i) |=>
            (!rd_valid_o || $stable(rd_data_o)));
endmodule

bind wsr_read_mux wsr_read_mux_chk #(.DW(DW)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .busy_i       (busy_i),
    .op_erase_i   (op_erase_i),
    .op_start_i   (op_start_i),
    .prog_data_i  (prog_data_i),
    .array_data_i (array_data_i),
    .rd_strobe_i  (rd_strobe_i),
    .ce_n_i       (ce_n_i),
    .oe_n_i       (oe_n_i),
    .rd_data_o    (rd_data_o),
    .rd_valid_o   (rd_valid_o)
);

// File: tb/wsr_read_mux_bench.sv
// Self-checking bench for wsr_read_mux.
module wsr_read_mux_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       busy = 1'b0, op_erase = 1'b0, op_start = 1'b0;
    logic [7:0] prog_data = '0, array_data = '0;
    logic       strobe = 1'b0, ce_n = 1'b1, oe_n = 1'b1;
    logic [7:0] rd_data;
    logic       rd_valid;

    int checks = 0, errors = 0;
    logic       exp_tog = 1'b0;
    logic [7:0] last_exp = '0;

    always #4 clk = ~clk;

    wsr_read_mux u_wsr_read_mux (
        .clk(clk), .rst_n(rst_n), .busy_i(busy), .op_erase_i(op_erase),
        .op_start_i(op_start), .prog_data_i(prog_data), .array_data_i(array_data),
        .rd_strobe_i(strobe), .ce_n_i(ce_n), .oe_n_i(oe_n),
        .rd_data_o(rd_data), .rd_valid_o(rd_valid)
    );

    function automatic logic [7:0] model(input logic b, input logic er,
                                         input logic [7:0] pd, input logic [7:0] ar,
                                         input logic t);
        if (!b) return ar;
        return {(er ? 1'b0 : ~pd[7]), t, ar[5:0]};
    endfunction

    task automatic check(input string req, input logic [8:0] act, input logic [8:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Start an internal operation (pulse op_start for one cycle).
    task automatic start_op(input logic er, input logic [7:0] pd);
        @(negedge clk);
        busy = 1'b1; op_erase = er; prog_data = pd; op_start = 1'b1;
        @(negedge clk);
        op_start = 1'b0;
        exp_tog = 1'b0;
    endtask

    // One accepted read with the given array byte; checks the result.
    task automatic do_read(input string req, input logic [7:0] ar);
        logic [7:0] e;
        @(negedge clk);
        ce_n = 1'b0; oe_n = 1'b0; array_data = ar; strobe = 1'b1;
        e = model(busy, op_erase, prog_data, ar, exp_tog);
        if (busy) exp_tog = ~exp_tog;
        @(negedge clk);
        check(req, {rd_valid, rd_data}, {1'b1, e});
        last_exp = e;
        strobe = 1'b0;
        @(negedge clk);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin : stim
        void'($urandom(32'd2468));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        ce_n = 1'b0; oe_n = 1'b0;
        @(negedge clk);
        // R9: reset state is zero, read through the driven bus.
        check("R9 reset", {rd_valid, rd_data}, 9'h100);

        // R5: idle read passes the array byte.
        do_read("R5 idle", 8'hA5);
        do_read("R5 idle", 8'h3C);

        // R1 R3 R4 R6: program with bit7 = 1, then bit7 = 0.
        start_op(1'b0, 8'h80);
        do_read("R6 first read after start", 8'h12);
        do_read("R3 R1 program", 8'h2B);
        do_read("R3 R4 program", 8'hFF);
        start_op(1'b0, 8'h00);
        do_read("R6 R1 restart", 8'h00);
        do_read("R3 R1 program b7=0", 8'h40);

        // R2: erase reads bit7 as 0.
        start_op(1'b1, 8'h00);
        do_read("R2 erase", 8'hFF);
        do_read("R2 R3 erase", 8'hC3);

        // R7 R8: strobe while deselected; output zero, toggle unchanged.
        @(negedge clk); ce_n = 1'b1; strobe = 1'b1;
        @(negedge clk); check("R8 deselected zero", {rd_valid, rd_data}, 9'h000);
        strobe = 1'b0;
        @(negedge clk); oe_n = 1'b1; ce_n = 1'b0; strobe = 1'b1;
        @(negedge clk); check("R8 oe high zero", {rd_valid, rd_data}, 9'h000);
        strobe = 1'b0;
        @(negedge clk); oe_n = 1'b0;
        @(negedge clk); check("R7 R10 held byte", {rd_valid, rd_data}, {1'b1, last_exp});
        do_read("R7 toggle not advanced", 8'h55);

        // R7: strobe held high counts as one read.
        @(negedge clk); array_data = 8'h0F; strobe = 1'b1;
        last_exp = model(1'b1, 1'b1, 8'h00, 8'h0F, exp_tog);
        exp_tog = ~exp_tog;
        repeat (4) @(negedge clk);
        array_data = 8'hF0;
        @(negedge clk); check("R7 R10 long strobe", {rd_valid, rd_data}, {1'b1, last_exp});
        strobe = 1'b0;
        @(negedge clk);
        do_read("R7 R3 after long strobe", 8'h11);

        // R5: completion; toggle frozen, full data returned.
        @(negedge clk); busy = 1'b0;
        do_read("R5 done erase", 8'hFF);
        do_read("R5 done again", 8'h7E);

        // Random mix of operations and reads.
        for (int op = 0; op < 40; op++) begin
            start_op(1'($urandom), 8'($urandom));
            for (int r = 0; r < 1 + ($urandom % 6); r++) begin
                if (($urandom % 4) == 0) begin
                    @(negedge clk); ce_n = 1'($urandom); oe_n = ~ce_n; strobe = 1'b1;
                    @(negedge clk); check("R8 R7 random ignored", {rd_valid, rd_data}, 9'h000);
                    strobe = 1'b0; ce_n = 1'b0; oe_n = 1'b0;
                    @(negedge clk);
                end
                do_read("R1 R2 R3 R4 random", 8'($urandom));
            end
            @(negedge clk); busy = 1'b0;
            do_read("R5 random idle", 8'($urandom));
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule